// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Controller

This block answers a cache refill request for one four-word block. The cache presents a block address with a request/ready handshake. The controller then reads the block from four interleaved banks. Word w of every block lives in bank w, so all four banks can be started on the same clock edge. Their accesses overlap, and only the trip back over the one-word return bus is serialised. The words come back one per cycle, in fixed order starting with word 0. Each word carries a valid strobe and its word index.

Each bank is an internal array with a fixed access latency. Its contents are set at reset from a formula, because this block carries no write traffic. A build-time parameter switches the controller to a non-overlapped mode. In that mode the banks are read one after another, which gives the cost of a plain one-word-wide memory for comparison.

Top module: `interleaved_refill_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `ready_o` is 1 and `rvalid_o` is 0.
- R2: A request is accepted on a rising edge where `req_i` and `ready_o` are both 1. `ready_o` is 0 from the edge after acceptance through the cycle that shows the last word. It is 1 again in the cycle after that.
- R3: In overlapped mode (`SEQUENTIAL`=0, `ACCESS_LAT`=25), word 0 is valid after the 26th rising edge following the acceptance edge. Words 1, 2 and 3 follow on the next three edges, so the last word is visible after edge 29. That is 30 cycles when the address cycle is counted. `rvalid_o` is 0 at every other point of the transfer.
- R4: Words are returned in the order 0, 1, 2, 3. `ridx_o` gives the word index, which is also the bank number, i.e. address bits [3:2] of that word.
- R5: Let r be address bits [7:4] of the request (the row index, taken modulo `ROWS`=16), and let a = r*4 + w. Then word w of the block is {a[15:0] XOR 16'hA5A5, a[15:0]}.
- R6: A request raised while `ready_o` is 0 is ignored. The words of the block in flight, their timing, and the state after it are unchanged.
- R7: With `SEQUENTIAL`=1, word w is valid after edge 26+26*w following acceptance, so the last word comes after edge 104 (105 cycles). `rvalid_o` is 0 between words.
- R8: A request raised in the first cycle that `ready_o` is 1 again is accepted at once and served with the same timing as the first.
- R9: Address bits [3:0] and the bits above the row index do not change the returned data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block refill request |
| addr_i | input | 32 | Byte address inside the wanted block |
| ready_o | output | 1 | Controller idle; a request is taken this cycle |
| rvalid_o | output | 1 | Return word valid |
| ridx_o | output | 2 | Index of the returned word in its block |
| rdata_o | output | 32 | Returned word |

## Verification
A bank timer that is off by one moves the first `rvalid_o` away from edge 26. That error shows on the very first refill. A sequencer that skips or repeats an index gives the wrong `ridx_o` or the wrong data pattern within the four return cycles. A lost busy state shows up as `ready_o` rising early. It also shows up as a second address being taken mid-block, and the next words then carry the wrong row's pattern. In sequential mode, a bank started at the wrong time moves every later word by a whole access period. That is visible by word 1.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND
  } ctrl_state_e;

  // fill pattern xor'ed into the upper half of each stored word
  localparam int unsigned MEM_PAT = 'hA5A5;
endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ROWS       = 16,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_ID    = 0,
  parameter int unsigned ACCESS_LAT = 25,
  localparam int unsigned RIDX_W    = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RIDX_W-1:0] row_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(ACCESS_LAT + 1);
  localparam int unsigned HALF  = DATA_W / 2;

  logic [DATA_W-1:0] mem [ROWS];
  logic [CNT_W-1:0]  cnt_q;
  logic [RIDX_W-1:0] row_q;

  function automatic logic [DATA_W-1:0] word_of(input int unsigned r);
    logic [HALF-1:0] wa;
    wa = HALF'(r * NUM_BANKS + BANK_ID);
    return {wa ^ HALF'(refill_pkg::MEM_PAT), wa};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= word_of(r);
      cnt_q  <= '0;
      row_q  <= '0;
      rdy_o  <= 1'b0;
      data_o <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(ACCESS_LAT);
      row_q <= row_i;
      rdy_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        rdy_o  <= 1'b1;
        data_o <= mem[row_q];
      end
    end
  end

  assert_start_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rdy_o);
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_BANKS  = 4,
  parameter bit          SEQUENTIAL = 1'b0,
  localparam int unsigned WIDX_W    = $clog2(NUM_BANKS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic [NUM_BANKS-1:0]             bank_rdy_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data_i,
  output logic                             ready_o,
  output logic                             accept_o,
  output logic [NUM_BANKS-1:0]             start_o,
  output logic                             rvalid_o,
  output logic [WIDX_W-1:0]                ridx_o,
  output logic [DATA_W-1:0]                rdata_o
);
  import refill_pkg::*;

  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(NUM_BANKS - 1);

  ctrl_state_e       state_q;
  logic [WIDX_W-1:0] widx_q;
  logic              cur_rdy;
  logic              chain;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = req_i && ready_o;
  assign cur_rdy  = bank_rdy_i[widx_q];
  // sequential mode: next bank starts when the current word is captured
  assign chain    = SEQUENTIAL && (state_q == ST_WAIT) && cur_rdy && (widx_q != LAST);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      start_o[b] = (accept_o && (!SEQUENTIAL || b == 0)) ||
                   (chain && (WIDX_W'(b) == widx_q + WIDX_W'(1)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      rvalid_o <= 1'b0;
      ridx_o   <= '0;
      rdata_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_WAIT;
          widx_q  <= '0;
        end
        ST_WAIT: if (cur_rdy) begin
          state_q  <= ST_SEND;
          rvalid_o <= 1'b1;
          ridx_o   <= widx_q;
          rdata_o  <= bank_data_i[widx_q];
        end
        ST_SEND: begin
          if (widx_q == LAST) begin
            state_q  <= ST_IDLE;
            rvalid_o <= 1'b0;
          end else if (SEQUENTIAL) begin
            state_q  <= ST_WAIT;
            rvalid_o <= 1'b0;
            widx_q   <= widx_q + 1'b1;
          end else begin
            widx_q  <= widx_q + 1'b1;
            ridx_o  <= widx_q + 1'b1;
            rdata_o <= bank_data_i[widx_q + 1'b1];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_while_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !ready_o);

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);

  if (SEQUENTIAL) begin : g_seq_chk
    assert_gap_between_words_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |=> !rvalid_o);
  end else begin : g_il_chk
    assert_word_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rvalid_o && ridx_o != LAST) |=> (rvalid_o && ridx_o == $past(ridx_o) + 1'b1));
    assert_first_index_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rvalid_o) |-> (ridx_o == '0));
  end
endmodule

// File: rtl/interleaved_refill_ctrl.sv
module interleaved_refill_ctrl #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned ROWS       = 16,
  parameter int unsigned ACCESS_LAT = 25,
  parameter bit          SEQUENTIAL = 1'b0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         ready_o,
  output logic                         rvalid_o,
  output logic [$clog2(NUM_BANKS)-1:0] ridx_o,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int unsigned WIDX_W    = $clog2(NUM_BANKS);
  localparam int unsigned RIDX_W    = $clog2(ROWS);
  localparam int unsigned BYTE_W    = $clog2(DATA_W / 8);
  localparam int unsigned ROW_LSB   = BYTE_W + WIDX_W;
  localparam int unsigned FINAL_LAT = SEQUENTIAL ? NUM_BANKS * (ACCESS_LAT + 1) + 1
                                                 : ACCESS_LAT + NUM_BANKS + 1;
  localparam int unsigned LAT_W     = $clog2(FINAL_LAT + 2);

  logic                             accept;
  logic [NUM_BANKS-1:0]             start;
  logic [NUM_BANKS-1:0]             bank_rdy;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
  logic [RIDX_W-1:0]                row_q, row_sel;

  assign row_sel = accept ? addr_i[ROW_LSB +: RIDX_W] : row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (accept) row_q <= addr_i[ROW_LSB +: RIDX_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    refill_bank #(
      .DATA_W    (DATA_W),
      .ROWS      (ROWS),
      .NUM_BANKS (NUM_BANKS),
      .BANK_ID   (b),
      .ACCESS_LAT(ACCESS_LAT)
    ) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start[b]),
      .row_i  (row_sel),
      .rdy_o  (bank_rdy[b]),
      .data_o (bank_data[b])
    );
  end

  refill_ctrl #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .SEQUENTIAL(SEQUENTIAL)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .bank_rdy_i (bank_rdy),
    .bank_data_i(bank_data),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .start_o    (start),
    .rvalid_o   (rvalid_o),
    .ridx_o     (ridx_o),
    .rdata_o    (rdata_o)
  );

  // cycle counter since acceptance, used only by the latency checks
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lat_q <= '0;
    else if (accept)        lat_q <= LAT_W'(1);
    else if (lat_q != '1)   lat_q <= lat_q + 1'b1;
  end

  assert_first_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rvalid_o) && ridx_o == '0) |-> (lat_q == LAT_W'(ACCESS_LAT + 2)));

  // covers R7 as well when SEQUENTIAL is set
  assert_last_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ridx_o == WIDX_W'(NUM_BANKS - 1)) |-> (lat_q == LAT_W'(FINAL_LAT)));
endmodule

// File: tb/test_interleaved_refill_ctrl.sv
module test_interleaved_refill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0;
  logic [31:0] addr_a = '0, addr_b = '0;
  logic        ready_a, rvalid_a, ready_b, rvalid_b;
  logic [1:0]  ridx_a, ridx_b;
  logic [31:0] rdata_a, rdata_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  interleaved_refill_ctrl #(.SEQUENTIAL(1'b0)) i_interleaved_refill_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .addr_i(addr_a),
    .ready_o(ready_a), .rvalid_o(rvalid_a), .ridx_o(ridx_a), .rdata_o(rdata_a));

  interleaved_refill_ctrl #(.SEQUENTIAL(1'b1)) i_interleaved_refill_ctrl_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .addr_i(addr_b),
    .ready_o(ready_b), .rvalid_o(rvalid_b), .ridx_o(ridx_b), .rdata_o(rdata_b));

  function automatic logic [31:0] exp_word(input logic [31:0] addr, input int w);
    logic [15:0] a;
    a = 16'(addr[7:4]) * 16'd4 + 16'(w);
    return {a ^ 16'hA5A5, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Issues one request and follows the block edge by edge.
  task automatic run_block(input bit seq, input logic [31:0] addr,
                           input int poke_at, input string req);
    int last;
    last = seq ? 104 : 29;
    chk((seq ? ready_b : ready_a) == 1'b1, "R2", "ready before request",
        seq ? ready_b : ready_a, 1);
    if (seq) begin req_b = 1'b1; addr_b = addr; end
    else     begin req_a = 1'b1; addr_a = addr; end
    @(posedge clk); #2;
    req_a = 1'b0; req_b = 1'b0;
    for (int n = 1; n <= last + 1; n++) begin
      int  w;
      bit  v, rv, rr;
      logic [1:0]  ri;
      logic [31:0] rd;
      if (n == poke_at) begin
        if (seq) begin req_b = 1'b1; addr_b = addr ^ 32'h0000_00F0; end
        else     begin req_a = 1'b1; addr_a = addr ^ 32'h0000_00F0; end
      end
      if (n == poke_at + 1) begin req_a = 1'b0; req_b = 1'b0; end
      @(posedge clk); #2;
      rv = seq ? rvalid_b : rvalid_a;
      rr = seq ? ready_b : ready_a;
      ri = seq ? ridx_b : ridx_a;
      rd = seq ? rdata_b : rdata_a;
      if (seq) begin
        v = (n >= 26) && ((n - 26) % 26 == 0) && ((n - 26) / 26 < 4);
        w = (n - 26) / 26;
      end else begin
        v = (n >= 26) && (n <= 29);
        w = n - 26;
      end
      if (v) begin
        chk(rv == 1'b1, req, "word valid", rv, 1);
        chk(ri == 2'(w), "R4", "word index", ri, w);
        chk(rd == exp_word(addr, w), "R5", "word data", rd, exp_word(addr, w));
      end else begin
        chk(rv == 1'b0, req, "no word expected", rv, 0);
      end
      chk(rr == (n == last + 1), "R2", "ready level", rr, (n == last + 1));
    end
  endtask

  task automatic test_reset();
    chk(ready_a == 1'b1 && ready_b == 1'b1, "R1", "ready in reset", {ready_a, ready_b}, 2'b11);
    chk(rvalid_a == 1'b0 && rvalid_b == 1'b0, "R1", "rvalid in reset", {rvalid_a, rvalid_b}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(ready_a == 1'b1 && rvalid_a == 1'b0, "R1", "interleaved after reset", {ready_a, rvalid_a}, 2'b10);
    chk(ready_b == 1'b1 && rvalid_b == 1'b0, "R1", "sequential after reset", {ready_b, rvalid_b}, 2'b10);
  endtask

  task automatic test_overlapped_basic();
    run_block(1'b0, 32'h0000_0040, 0, "R3");
  endtask

  task automatic test_address_bits_ignored();
    // row 0xB with all other bits set; data must match row 0xB alone (R9)
    run_block(1'b0, 32'hFFFF_FFBF, 0, "R9");
  endtask

  task automatic test_request_while_busy();
    run_block(1'b0, 32'h0000_0070, 5,  "R6");
    run_block(1'b0, 32'h0000_0020, 27, "R6");
  endtask

  task automatic test_back_to_back();
    run_block(1'b0, 32'h0000_00E0, 0, "R8");
    run_block(1'b0, 32'h0000_0010, 0, "R8");
  endtask

  task automatic test_sequential();
    run_block(1'b1, 32'h0000_0050, 0,  "R7");
    run_block(1'b1, 32'h0000_00C4, 40, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    test_reset();
    test_overlapped_basic();
    test_address_bits_ignored();
    test_request_while_busy();
    test_back_to_back();
    test_sequential();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule